// File: doc/BRIEF.md
# Indirect CSR Access Permission Checker

This block decides whether an instruction that touches one of the indirect-access control registers may go ahead. There are two kinds of such register. The select register holds an index. An alias register forwards the access to whatever target the index picks. The block takes the 12-bit register address, the write flag, the current privilege, the virtualization bit, and the two state-enable gate bits. It returns a two-bit fault class: allowed, illegal instruction, or virtual instruction.

The rules are tried in a fixed order, and the first one that fires sets the result:

1. State-enable gating.
2. The rules that apply under virtualization.
3. The check for an alias with no implemented target.
4. The ordinary privilege and read-only checks.

A request strobe is registered together with the result. The fault class and its valid flag therefore reach the pipeline one clock after the request.

Top module: `csrind_perm_chk`

## Requirements
- R1: The fault code on `fault_o` is 00 for allowed, 01 for illegal instruction and 10 for virtual instruction. The code 11 never appears while `valid_o` is high.
- R2: A request in one cycle gives `valid_o` high in the next cycle, with that request's result. A cycle with no request gives `valid_o` low in the next cycle. Reset clears `valid_o`.
- R3: The state-enable gate applies when all three of these hold:
  - `stateen_en_i` is high.
  - The privilege (U=00, S=01, M=11) is below M.
  - The register is a select register, or an alias register whose address bits [9:8] are below 3.

  When the gate applies and `m_csrind_i` is low, the result is illegal.
- R4: When the gate applies, `m_csrind_i` is high, `virt_i` is high and `h_csrind_i` is low, the result is virtual.
- R5: With `stateen_en_i` low, the two gate bits have no effect.
- R6: An alias register whose address bits [9:8] equal 3 skips both the state-enable gate and the virtualization rules.
- R7: With `virt_i` high, an address whose bits [9:8] equal 2 gives virtual, unless the gate has already fired. A gate result wins over this rule.
- R8: With `virt_i` high and privilege U, any other select or alias register below M gives virtual. This takes priority over the ordinary privilege check.
- R9: An alias access whose target is not implemented (`tgt_impl_i` low) gives illegal whatever `virt_i` is, once R3 to R8 pass. For select registers, `tgt_impl_i` is ignored.
- R10: When the privilege is below the address bits [9:8], the result is illegal.
- R11: A write to an address whose bits [11:10] equal 3 gives illegal. A read of the same address is not refused for this reason.
- R12: An access that no rule refuses gives 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe |
| csr_addr_i | input | 12 | Register address of the access |
| write_i | input | 1 | Access writes the register |
| is_alias_i | input | 1 | 1 = alias register, 0 = select register |
| tgt_impl_i | input | 1 | The selected alias target is implemented |
| priv_i | input | 2 | Current privilege: U=00, S=01, M=11 |
| virt_i | input | 1 | Virtualization bit |
| stateen_en_i | input | 1 | State-enable extension is active |
| m_csrind_i | input | 1 | Machine-level indirect-access enable bit |
| h_csrind_i | input | 1 | Hypervisor-level indirect-access enable bit |
| valid_o | output | 1 | Result valid, one cycle after the request |
| fault_o | output | 2 | Fault class |

## Verification
The hardest cases to reach are those where a higher-priority rule hides a lower one. In each of them, two rules would give different fault classes for the same access.

The stimulus sets up exactly those collisions:
- A virtualized user-mode access to a supervisor register: the ordinary check would say illegal, but the expected answer is virtual.
- A virtual-supervisor copy with the machine gate closed: the expected answer is illegal.
- A machine-level alias with the hypervisor gate closed. Here the gate skip shows up as illegal instead of virtual, while the matching select register gives virtual.

// File: rtl/csrind_pkg.sv
package csrind_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_ILL  = 2'b01,
    FLT_VIRT = 2'b10
  } fault_e;

  localparam int unsigned PRIV_W = 2;
  localparam logic [PRIV_W-1:0] PRIV_U  = 2'b00;
  localparam logic [PRIV_W-1:0] PRIV_S  = 2'b01;
  localparam logic [PRIV_W-1:0] PRIV_VS = 2'b10;
  localparam logic [PRIV_W-1:0] PRIV_M  = 2'b11;
endpackage

// File: rtl/csrind_stateen_gate.sv
module csrind_stateen_gate
  import csrind_pkg::*;
(
  input  logic              en_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic [PRIV_W-1:0] addr_priv_i,
  input  logic              is_alias_i,
  input  logic              virt_i,
  input  logic              m_bit_i,
  input  logic              h_bit_i,
  output logic              hit_o,
  output fault_e            fault_o
);
  logic applies;

  // alias registers at machine level bypass the gate
  always_comb begin
    applies = en_i && (priv_i != PRIV_M) && (!is_alias_i || addr_priv_i != PRIV_M);
    hit_o   = applies && (!m_bit_i || (virt_i && !h_bit_i));
    fault_o = !m_bit_i ? FLT_ILL : FLT_VIRT;
  end
endmodule

// File: rtl/csrind_virt_rule.sv
module csrind_virt_rule
  import csrind_pkg::*;
(
  input  logic              virt_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic [PRIV_W-1:0] addr_priv_i,
  input  logic              is_alias_i,
  output logic              hit_o
);
  logic applies;

  always_comb begin
    applies = virt_i && (!is_alias_i || addr_priv_i != PRIV_M);
    hit_o   = applies && (addr_priv_i == PRIV_VS || priv_i == PRIV_U);
  end
endmodule

// File: rtl/csrind_base_rule.sv
module csrind_base_rule
  import csrind_pkg::*;
(
  input  logic [PRIV_W-1:0] priv_i,
  input  logic [PRIV_W-1:0] addr_priv_i,
  input  logic              ro_space_i,
  input  logic              write_i,
  input  logic              is_alias_i,
  input  logic              tgt_impl_i,
  output logic              tgt_hit_o,
  output logic              base_hit_o
);
  always_comb begin
    tgt_hit_o  = is_alias_i && !tgt_impl_i;
    base_hit_o = (priv_i < addr_priv_i) || (write_i && ro_space_i);
  end
endmodule

// File: rtl/csrind_perm_chk.sv
module csrind_perm_chk
  import csrind_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned PRIV_LSB = 8,
  parameter int unsigned RO_LSB   = 10,
  parameter bit          OUT_REG  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic              write_i,
  input  logic              is_alias_i,
  input  logic              tgt_impl_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic              stateen_en_i,
  input  logic              m_csrind_i,
  input  logic              h_csrind_i,
  output logic              valid_o,
  output logic [1:0]        fault_o
);
  localparam int unsigned PRIV_MSB = PRIV_LSB + PRIV_W - 1;
  localparam int unsigned RO_MSB   = RO_LSB + 1;

  logic [PRIV_W-1:0] addr_priv;
  logic              ro_space;
  logic              gate_hit, virt_hit, tgt_hit, base_hit;
  fault_e            gate_fault, fault_d;

  assign addr_priv = csr_addr_i[PRIV_MSB:PRIV_LSB];
  assign ro_space  = &csr_addr_i[RO_MSB:RO_LSB];

  csrind_stateen_gate i_gate (
    .en_i        (stateen_en_i),
    .priv_i      (priv_i),
    .addr_priv_i (addr_priv),
    .is_alias_i  (is_alias_i),
    .virt_i      (virt_i),
    .m_bit_i     (m_csrind_i),
    .h_bit_i     (h_csrind_i),
    .hit_o       (gate_hit),
    .fault_o     (gate_fault)
  );

  csrind_virt_rule i_virt (
    .virt_i      (virt_i),
    .priv_i      (priv_i),
    .addr_priv_i (addr_priv),
    .is_alias_i  (is_alias_i),
    .hit_o       (virt_hit)
  );

  csrind_base_rule i_base (
    .priv_i      (priv_i),
    .addr_priv_i (addr_priv),
    .ro_space_i  (ro_space),
    .write_i     (write_i),
    .is_alias_i  (is_alias_i),
    .tgt_impl_i  (tgt_impl_i),
    .tgt_hit_o   (tgt_hit),
    .base_hit_o  (base_hit)
  );

  // fixed priority: gate, virtualization, missing target, base
  always_comb begin
    if (gate_hit)      fault_d = gate_fault;
    else if (virt_hit) fault_d = FLT_VIRT;
    else if (tgt_hit)  fault_d = FLT_ILL;
    else if (base_hit) fault_d = FLT_ILL;
    else               fault_d = FLT_NONE;
  end

  generate
    if (OUT_REG) begin : g_reg
      logic   valid_q;
      fault_e fault_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_q <= 1'b0;
          fault_q <= FLT_NONE;
        end else begin
          valid_q <= req_i;
          if (req_i) fault_q <= fault_d;
        end
      end

      assign valid_o = valid_q;
      assign fault_o = fault_q;

      a_r2_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> valid_o);
      a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !valid_o);
      a_r1_no_reserved_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> fault_o != 2'b11);
      a_r3_mstateen_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && stateen_en_i && priv_i != PRIV_M && !m_csrind_i && !is_alias_i)
        |=> fault_o == FLT_ILL);
      a_r7_vs_copy_virtual: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && virt_i && !stateen_en_i && addr_priv == PRIV_VS) |=> fault_o == FLT_VIRT);
      a_r9_missing_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && is_alias_i && !tgt_impl_i && !virt_i && !stateen_en_i) |=> fault_o == FLT_ILL);
    end else begin : g_comb
      assign valid_o = req_i;
      assign fault_o = fault_d;
    end
  endgenerate
endmodule

// File: tb/test_csrind_perm_chk.sv
`timescale 1ns/1ps
module test_csrind_perm_chk;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [11:0] csr_addr_i = '0;
  logic        write_i = 1'b0, is_alias_i = 1'b0, tgt_impl_i = 1'b1;
  logic [1:0]  priv_i = 2'b11;
  logic        virt_i = 1'b0, stateen_en_i = 1'b0, m_csrind_i = 1'b1, h_csrind_i = 1'b1;
  logic        valid_o;
  logic [1:0]  fault_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;
  localparam logic [1:0] OK = 2'b00, ILL = 2'b01, VIR = 2'b10;

  always #2 clk_i = ~clk_i;

  csrind_perm_chk i_csrind_perm_chk (
    .clk_i, .rst_ni, .req_i, .csr_addr_i, .write_i, .is_alias_i, .tgt_impl_i,
    .priv_i, .virt_i, .stateen_en_i, .m_csrind_i, .h_csrind_i, .valid_o, .fault_o
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // issue one request, sample valid/fault one cycle later
  task automatic access(input string tag, input logic [11:0] addr, input logic wr,
                        input logic alias_reg, input logic impl, input logic [1:0] prv,
                        input logic v, input logic en, input logic mb, input logic hb,
                        input logic [1:0] exp);
    @(negedge clk_i);
    csr_addr_i = addr; write_i = wr; is_alias_i = alias_reg; tgt_impl_i = impl;
    priv_i = prv; virt_i = v; stateen_en_i = en; m_csrind_i = mb; h_csrind_i = hb;
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    check({tag, " valid"}, {1'b0, valid_o}, 2'b01);
    check(tag, fault_o, exp);
  endtask

  task automatic t_reset;
    check("R2 reset valid", {1'b0, valid_o}, 2'b00);
  endtask

  task automatic t_allowed;
    access("R12 S select", 12'h150, 0, 0, 1, S, 0, 1, 1, 1, OK);
    access("R12 M alias",  12'h351, 1, 1, 1, M, 0, 1, 0, 0, OK);
    access("R1 VS read gate open", 12'h151, 0, 1, 1, S, 1, 1, 1, 1, OK);
  endtask

  task automatic t_gate;
    access("R3 select m clear", 12'h150, 0, 0, 1, S, 0, 1, 0, 1, ILL);
    access("R3 alias m clear",  12'h151, 0, 1, 1, U, 0, 1, 0, 1, ILL);
    access("R3 M priv bypass",  12'h150, 0, 0, 1, M, 0, 1, 0, 0, OK);
    access("R4 h clear",        12'h150, 0, 0, 1, S, 1, 1, 1, 0, VIR);
    access("R5 gate off",       12'h150, 1, 0, 1, S, 0, 0, 0, 0, OK);
    access("R6 M alias skips",  12'h351, 0, 1, 1, S, 1, 1, 1, 0, ILL);
    access("R6 M select gated", 12'h350, 0, 0, 1, S, 1, 1, 1, 0, VIR);
  endtask

  task automatic t_virt;
    access("R7 VS select",      12'h250, 0, 0, 1, S, 1, 1, 1, 1, VIR);
    access("R7 VS alias",       12'h251, 0, 1, 1, S, 1, 0, 0, 0, VIR);
    access("R7 gate wins",      12'h250, 0, 0, 1, S, 1, 1, 0, 1, ILL);
    access("R8 VU select",      12'h150, 0, 0, 1, U, 1, 0, 1, 1, VIR);
    access("R8 VU alias",       12'h151, 1, 1, 0, U, 1, 1, 1, 1, VIR);
  endtask

  task automatic t_target;
    access("R9 missing V=1",    12'h151, 0, 1, 0, S, 1, 1, 1, 1, ILL);
    access("R9 missing V=0",    12'h151, 0, 1, 0, S, 0, 0, 1, 1, ILL);
    access("R9 select ignores", 12'h150, 0, 0, 0, S, 0, 0, 1, 1, OK);
  endtask

  task automatic t_base;
    access("R10 U to S reg",    12'h150, 0, 0, 1, U, 0, 0, 1, 1, ILL);
    access("R10 S to M reg",    12'h350, 0, 0, 1, S, 0, 0, 1, 1, ILL);
    access("R11 ro write",      12'hD51, 1, 1, 1, S, 0, 0, 1, 1, ILL);
    access("R11 ro read",       12'hD51, 0, 1, 1, S, 0, 0, 1, 1, OK);
  endtask

  task automatic t_timing;
    // back-to-back requests, then idle
    @(negedge clk_i);
    csr_addr_i = 12'h150; priv_i = U; virt_i = 0; stateen_en_i = 0; is_alias_i = 0;
    write_i = 0; req_i = 1'b1;
    @(negedge clk_i);
    check("R2 first result", fault_o, ILL);
    priv_i = S;
    @(negedge clk_i);
    req_i = 1'b0;
    check("R2 second valid", {1'b0, valid_o}, 2'b01);
    check("R2 second result", fault_o, OK);
    @(negedge clk_i);
    check("R2 idle drops valid", {1'b0, valid_o}, 2'b00);
    check("R1 held code legal", {1'b0, fault_o == 2'b11}, 2'b00);
  endtask

  initial begin
    #(200000 * 4);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_allowed();
    t_gate();
    t_virt();
    t_target();
    t_base();
    t_timing();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule